// File: doc/BRIEF.md
# Serial Flash Read Responder

This block sits on the device side of a byte-oriented serial link and answers for a flash part that stores boot code. Each time the controller strobes a byte in, it also presents a hold flag that says whether the chip select stays active after this byte. The block returns one response byte per strobed byte. The controller reads that byte on the next transfer.

A held transaction opens with an opcode byte. The only opcode the block serves is the plain read, 0x03. After the opcode, the next three bytes give a 24-bit start address, with the highest byte sent first. Every byte after that returns the stored byte at the current address and then moves the address up by one. Addresses past the end of the array read as zero; they do not wrap. Any other opcode is accepted and then ignored.

The array size is a parameter. A synchronous backdoor port lets a bench or loader fill the array before use.

Top module: `flash_read_responder`

## Requirements
- R1: While reset is high at a clock edge, the response byte, the opcode, the address, the byte position and the open-transaction flag are all cleared to zero.
- R2: A strobed byte with hold high, when no transaction is open, is taken as the opcode and opens a transaction. The response byte keeps its previous value.
- R3: With opcode 0x03, the three strobed bytes after the opcode form the 24-bit address, most significant byte first. Each of them sets the response byte to 0x00.
- R4: With opcode 0x03, every strobed byte after the third address byte loads the response with the stored byte at the current address, and the address then increases by one.
- R5: When the current address is equal to or greater than MEM_BYTES, the data byte returned is 0x00 and the address still increases.
- R6: A strobed byte with hold low is handled under the current opcode and closes the transaction. The next strobed byte with hold high is taken as a new opcode.
- R7: When the opcode is anything other than 0x03, the following strobed bytes leave the response byte unchanged.
- R8: The response byte changes only at the clock edge that samples a strobe, so it is valid from the cycle after the strobe. With no strobe it holds its value.
- R9: A backdoor write with bd_we high stores bd_data at index bd_idx at the clock edge. Reads see the new value from then on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_stb | input | 1 | One-cycle strobe: a byte has arrived |
| xfer_byte | input | 8 | Received byte |
| xfer_hold | input | 1 | High: chip select stays active after this byte |
| rsp_byte | output | 8 | Registered response byte |
| bd_we | input | 1 | Backdoor write enable |
| bd_idx | input | IDX_W | Backdoor byte index |
| bd_data | input | 8 | Backdoor write data |

## Verification
Every response is due in the cycle right after its strobe: one register lies between xfer_stb and rsp_byte, and the array read is combinational. The bench raises the strobe for one cycle at a falling edge and updates its own model once the next rising edge has passed. It then compares rsp_byte against the model at the following falling edge. In the idle cycles between bytes, it keeps comparing on every falling edge, which confirms that the response holds. Backdoor writes take effect at one edge, and they are checked indirectly through later reads.

// File: rtl/flash_resp_pkg.sv
package flash_resp_pkg;

    localparam int          ADDR_BITS  = 24;
    localparam logic [7:0]  OPC_READ   = 8'h03;
    localparam logic [2:0]  POS_STREAM = 3'd4;

    typedef struct packed {
        logic                 active;
        logic [7:0]           opcode;
        logic [2:0]           pos;
        logic [ADDR_BITS-1:0] addr;
    } seq_state_t;

    function automatic logic [ADDR_BITS-1:0] shift_addr(
        input logic [ADDR_BITS-1:0] cur,
        input logic [7:0]           nxt
    );
        return {cur[ADDR_BITS-9:0], nxt};
    endfunction

endpackage

// File: rtl/flash_byte_store.sv
module flash_byte_store
    import flash_resp_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W = $clog2(MEM_BYTES)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_data,
    input  logic [ADDR_BITS-1:0] rd_addr,
    output logic [7:0]           rd_data
);

    localparam logic [ADDR_BITS-1:0] LIMIT = ADDR_BITS'(MEM_BYTES);

    logic [7:0] mem [MEM_BYTES];

    always_ff @(posedge clk) begin
        if (wr_en && ({{(ADDR_BITS-IDX_W){1'b0}}, wr_idx} < LIMIT))
            mem[wr_idx] <= wr_data;
    end

    always_comb begin
        if (rd_addr < LIMIT)
            rd_data = mem[rd_addr[IDX_W-1:0]];
        else
            rd_data = 8'h00;
    end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_resp_pkg::*;
#(
    parameter int MEM_BYTES = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stb,
    input  logic [7:0]           din,
    input  logic                 hold,
    input  logic [7:0]           rd_data,
    output logic [ADDR_BITS-1:0] rd_addr,
    output logic [7:0]           rsp
);

    seq_state_t st;
    logic       opens;
    logic       takes_data;
    logic       is_read;

    assign opens      = stb && hold && !st.active;
    assign takes_data = stb && !opens;
    assign is_read    = (st.opcode == OPC_READ);
    assign rd_addr    = st.addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= '0;
            rsp <= 8'h00;
        end else if (opens) begin
            st.active <= 1'b1;
            st.opcode <= din;
            st.pos    <= 3'd1;
            st.addr   <= '0;
        end else if (takes_data) begin
            if (!hold)
                st.active <= 1'b0;
            if (is_read) begin
                if (st.pos < POS_STREAM) begin
                    st.addr <= shift_addr(st.addr, din);
                    rsp     <= 8'h00;
                end else begin
                    rsp     <= rd_data;
                    st.addr <= st.addr + 1'b1;
                end
                if (st.pos != POS_STREAM)
                    st.pos <= st.pos + 3'd1;
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rsp == 8'h00) && !st.active && (st.addr == '0) && (st.opcode == 8'h00));

    // R2
    opcode_no_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        opens |=> $stable(rsp) && st.active);

    // R3
    addr_phase_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (takes_data && is_read && (st.pos < POS_STREAM)) |=> (rsp == 8'h00));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (takes_data && is_read && (st.pos == POS_STREAM)) |=> (st.addr == $past(st.addr) + 1'b1));

    // R5
    beyond_end_chk: assert property (@(posedge clk) disable iff (rst)
        (takes_data && is_read && (st.pos == POS_STREAM) && (st.addr >= ADDR_BITS'(MEM_BYTES)))
        |=> (rsp == 8'h00));

    // R6
    txn_close_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && !hold) |=> !st.active);

    // R7
    unknown_op_chk: assert property (@(posedge clk) disable iff (rst)
        (takes_data && !is_read) |=> $stable(rsp));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(rsp));

endmodule

// File: rtl/flash_read_responder.sv
module flash_read_responder
    import flash_resp_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W = $clog2(MEM_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer_stb,
    input  logic [7:0]       xfer_byte,
    input  logic             xfer_hold,
    output logic [7:0]       rsp_byte,
    input  logic             bd_we,
    input  logic [IDX_W-1:0] bd_idx,
    input  logic [7:0]       bd_data
);

    logic [ADDR_BITS-1:0] cur_addr;
    logic [7:0]           cur_data;

    flash_cmd_seq #(
        .MEM_BYTES(MEM_BYTES)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .stb     (xfer_stb),
        .din     (xfer_byte),
        .hold    (xfer_hold),
        .rd_data (cur_data),
        .rd_addr (cur_addr),
        .rsp     (rsp_byte)
    );

    flash_byte_store #(
        .MEM_BYTES(MEM_BYTES)
    ) u_store (
        .clk     (clk),
        .wr_en   (bd_we),
        .wr_idx  (bd_idx),
        .wr_data (bd_data),
        .rd_addr (cur_addr),
        .rd_data (cur_data)
    );

endmodule

// File: tb/flash_read_responder_tb.sv
module flash_read_responder_tb;

    localparam int MEM_BYTES = 1024;
    localparam int IDX_W     = $clog2(MEM_BYTES);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             xfer_stb = 1'b0;
    logic [7:0]       xfer_byte = 8'h00;
    logic             xfer_hold = 1'b0;
    logic [7:0]       rsp_byte;
    logic             bd_we = 1'b0;
    logic [IDX_W-1:0] bd_idx = '0;
    logic [7:0]       bd_data = 8'h00;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    string cur_req = "R1";

    int m_mem [MEM_BYTES];
    bit m_act = 1'b0;
    int m_cmd = 0;
    int m_pos = 0;
    int m_addr = 0;
    int m_rsp = 0;

    always #4 clk = ~clk;

    flash_read_responder #(.MEM_BYTES(MEM_BYTES)) u_dut (
        .clk(clk), .rst(rst), .xfer_stb(xfer_stb), .xfer_byte(xfer_byte),
        .xfer_hold(xfer_hold), .rsp_byte(rsp_byte), .bd_we(bd_we),
        .bd_idx(bd_idx), .bd_data(bd_data)
    );

    task automatic cmp();
        checks++;
        if (int'(rsp_byte) !== m_rsp) begin
            failures++;
            $display("FAIL %s: rsp_byte actual=%02h expected=%02h at %0t",
                     cur_req, rsp_byte, m_rsp[7:0], $time);
        end
    endtask

    task automatic model_step(input int b, input bit h);
        if (h && !m_act) begin
            m_act = 1'b1; m_cmd = b; m_pos = 1; m_addr = 0;
        end else begin
            if (!h) m_act = 1'b0;
            if (m_cmd == 8'h03) begin
                if (m_pos < 4) begin
                    m_addr = ((m_addr << 8) | b) & 32'h00FF_FFFF;
                    m_rsp  = 0;
                end else begin
                    m_rsp  = (m_addr < MEM_BYTES) ? m_mem[m_addr] : 0;
                    m_addr = (m_addr + 1) & 32'h00FF_FFFF;
                end
                if (m_pos < 4) m_pos++;
            end
        end
    endtask

    task automatic send(input int b, input bit h, input int gap);
        @(negedge clk);
        xfer_stb = 1'b1; xfer_byte = b[7:0]; xfer_hold = h;
        @(negedge clk);
        xfer_stb = 1'b0;
        model_step(b, h);
        cmp();
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            cmp();
        end
    endtask

    task automatic bd_write(input int idx, input int val);
        @(negedge clk);
        bd_we = 1'b1; bd_idx = idx[IDX_W-1:0]; bd_data = val[7:0];
        @(negedge clk);
        bd_we = 1'b0;
        m_mem[idx] = val & 255;
    endtask

    task automatic read_seq(input int addr, input int n, input bit end_low);
        send(8'h03, 1'b1, 1);
        send((addr >> 16) & 255, 1'b1, 0);
        send((addr >> 8) & 255, 1'b1, 2);
        send(addr & 255, 1'b1, 0);
        for (int i = 0; i < n; i++)
            send(8'hA5, !(end_low && (i == n - 1)), i % 2);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        cmp();
        rst = 1'b0;
        @(negedge clk);
        cmp();

        // R9: backdoor preload
        cur_req = "R9";
        for (int i = 0; i < MEM_BYTES; i++)
            bd_write(i, (i * 7 + 3) & 255);
        cmp();

        // R2 R3 R4: read from 0x000102 (MSB first matters)
        cur_req = "R3";
        read_seq(32'h000102, 1, 1'b0);
        cur_req = "R4";
        for (int i = 0; i < 4; i++) send(8'h00, 1'b1, 1);
        // R6: last byte with hold low is still served, then closes
        cur_req = "R6";
        send(8'h00, 1'b0, 2);

        // R5: stream across the end of the array
        cur_req = "R5";
        read_seq(MEM_BYTES - 3, 6, 1'b1);

        // R4: a fresh read ending on nonzero data
        cur_req = "R4";
        read_seq(32'h000040, 3, 1'b1);

        // R7: unknown opcode leaves rsp untouched
        cur_req = "R7";
        send(8'h9F, 1'b1, 1);
        for (int i = 0; i < 5; i++) send(8'h03, 1'b1, 0);
        send(8'h11, 1'b0, 1);

        // R2: opcode byte keeps previous rsp; high address out of range
        cur_req = "R2";
        read_seq(32'h010005, 2, 1'b1);

        // R9: overwrite then read back
        cur_req = "R9";
        bd_write(5, 8'hC3);
        bd_write(6, 8'h3C);
        read_seq(32'h000005, 2, 1'b1);

        // R8: long idle, rsp must hold
        cur_req = "R8";
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            cmp();
        end

        // R1: reset mid-transaction clears everything
        cur_req = "R1";
        send(8'h03, 1'b1, 0);
        send(8'h00, 1'b1, 0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_act = 1'b0; m_cmd = 0; m_pos = 0; m_addr = 0; m_rsp = 0;
        cmp();
        // R6: after reset a held byte is an opcode
        cur_req = "R6";
        read_seq(32'h000020, 2, 1'b1);

        report();
    end

endmodule